// File: doc/BRIEF.md
# Interleaved Block-Fill Memory Reader

This block serves cache block fills from a main memory that is split into a power-of-two number of banks, with consecutive word addresses placed in consecutive banks. A fill request carries a word address. The controller aligns that address down to the block length and then sends one word address per cycle, each to a different bank. Every bank takes a fixed number of cycles to produce its word. Because the bank accesses overlap, a block costs about one access time plus one cycle per word. A plain single-bank memory with the same timing would pay the whole access time again for every word.

Requests use a valid/ready handshake. Words come back in ascending address order over a one-word return path, with a flag on the final word. Each bank keeps a countdown of its remaining access time and takes no new address until that countdown has run out. Bank contents are a fixed, read-only function of the word address, so a fill can be checked without any write path.

Top module: `ilv_mem_reader`

## Requirements
- R1: After reset, rsp_valid_o is 0 and req_ready_o is 1.
- R2: Word address A sits in bank A mod NUM_BANKS, at location A div NUM_BANKS inside that bank. The word returned for A equals the low DATA_W bits of (A * 32'h9E3779B1) XOR 32'h3C5A96E1, where A is zero-extended to 32 bits and the product is truncated to 32 bits.
- R3: A bank that takes an address is busy for ACCESS_LAT cycles. It takes no further address until its countdown reaches zero, and at most one bank takes an address in any cycle.
- R4: The words of a block arrive in ascending address order, on consecutive cycles. With NUM_BANKS >= ACCESS_LAT, the first word is valid ACCESS_LAT+2 cycles after the cycle in which the request was accepted, and rsp_valid_o is 0 at all other times.
- R5: rsp_last_o is 1 only together with the final word of a block, that is word BLOCK_WORDS-1.
- R6: The last word of a block is presented ACCESS_LAT+BLOCK_WORDS+1 cycles after the acceptance cycle. With the defaults that is 11 cycles, fewer than the 32 cycles a non-interleaved memory needs for a 4-word block.
- R7: req_ready_o is 0 from the cycle after an acceptance until the cycle in which the final word is presented. A req_valid_i raised while req_ready_o is 0 has no effect on the returned words or their timing.
- R8: The low log2(BLOCK_WORDS) bits of req_addr_i are ignored. The block starts at the address with those bits cleared.
- R9: A request raised in the same cycle as the previous block's final word is accepted, and that block is served with the timing of R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Block fill request is present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ADDR_W | Word address inside the wanted block |
| rsp_valid_o | output | 1 | A returned word is on rsp_data_o |
| rsp_data_o | output | DATA_W | Returned word |
| rsp_last_o | output | 1 | Returned word is the last of its block |

## Verification
The bench fires requests with unaligned addresses, and one at the very top of the address space. A design that failed to clear the offset bits would return the wrong words, or would start part-way into a block and wrap into the next bank group. It raises junk requests while a fill is still running. A controller that took one of them would corrupt the bank pointer, or would send a second stream of words. It chains a new request into the cycle in which the last word is presented, and it checks every output on every cycle against the exact first-word and last-word cycles. An off-by-one in the bank countdown, in the return register or in the ready release therefore shows up as a shifted or missing word, or as a misplaced last flag.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Fixed read-only bank contents: a scrambled function of the word address.
    function automatic logic [31:0] ilv_word_value(input logic [31:0] word_addr);
        logic [31:0] prod;
        prod = word_addr * 32'h9E3779B1;
        return prod ^ 32'h3C5A96E1;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int NUM_BANKS  = 8,
    parameter int ACCESS_LAT = 6,
    parameter int BANK_IDX   = 0
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  issue_i,
    input  logic [ADDR_W-$clog2(NUM_BANKS)-1:0]   loc_i,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic [DATA_W-1:0]                     data_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LOC_W  = ADDR_W - BANK_W;
    localparam int CNT_W  = $clog2(ACCESS_LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LOC_W-1:0] loc;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [ADDR_W-1:0] full_addr;
    logic [31:0]       word_val;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (issue_i) begin
            st_d.cnt = CNT_W'(ACCESS_LAT);
            st_d.loc = loc_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.cnt != '0);
    assign done_o    = (st_q.cnt == CNT_W'(1));
    assign full_addr = {st_q.loc, BANK_W'(BANK_IDX)};
    assign word_val  = ilv_pkg::ilv_word_value(32'(full_addr));
    assign data_o    = DATA_W'(word_val);

    // R3: a bank never takes an address while its countdown is running
    a_r3_no_issue_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i |-> !busy_o);

    // R3: the final countdown cycle frees the bank on the next cycle
    a_r3_free_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !issue_i) |=> !busy_o);

    // R3: an accepted address makes the bank busy on the next cycle
    a_r3_busy_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i |=> (busy_o && !done_o));
endmodule

// File: rtl/ilv_issue.sv
module ilv_issue #(
    parameter int ADDR_W      = 12,
    parameter int NUM_BANKS   = 8,
    parameter int BLOCK_WORDS = 4
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  start_i,
    input  logic [ADDR_W-1:0]                     base_i,
    input  logic [NUM_BANKS-1:0]                  bank_busy_i,
    output logic [NUM_BANKS-1:0]                  issue_o,
    output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]   loc_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LOC_W  = ADDR_W - BANK_W;
    localparam int IDX_W  = $clog2(BLOCK_WORDS);

    typedef struct packed {
        logic              run;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
    } issue_state_t;

    issue_state_t      st_d, st_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [BANK_W-1:0] cur_bank;

    assign cur_addr = st_q.base + ADDR_W'(st_q.idx);
    assign cur_bank = cur_addr[BANK_W-1:0];
    assign loc_o    = cur_addr[ADDR_W-1:BANK_W];

    always_comb begin
        st_d    = st_q;
        issue_o = '0;
        if (st_q.run && !bank_busy_i[cur_bank]) begin
            issue_o[cur_bank] = 1'b1;
            st_d.idx          = st_q.idx + IDX_W'(1);
            if (st_q.idx == IDX_W'(BLOCK_WORDS - 1)) begin
                st_d.run = 1'b0;
            end
        end
        if (start_i) begin
            st_d.run  = 1'b1;
            st_d.base = base_i;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: one address sent per cycle at most
    a_r3_one_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(issue_o));

    // R3: no address is steered at a bank that reports busy
    a_r3_issue_free_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_o & bank_busy_i) == '0);

    // R7: a new block never starts while the previous one is still being sent
    a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !st_q.run);
endmodule

// File: rtl/ilv_return.sv
module ilv_return #(
    parameter int DATA_W      = 32,
    parameter int NUM_BANKS   = 8,
    parameter int BLOCK_WORDS = 4
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                start_i,
    input  logic [$clog2(NUM_BANKS)-1:0]        start_bank_i,
    input  logic [NUM_BANKS-1:0]                done_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]    data_i,
    output logic                                rsp_valid_o,
    output logic [DATA_W-1:0]                   rsp_data_o,
    output logic                                rsp_last_o,
    output logic                                finish_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = $clog2(BLOCK_WORDS);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              last;
        logic [IDX_W-1:0]  cnt;
        logic [BANK_W-1:0] exp_bank;
    } ret_state_t;

    ret_state_t st_d, st_q;
    logic       hit;
    logic       final_word;

    assign hit        = |done_i;
    assign final_word = (st_q.cnt == IDX_W'(BLOCK_WORDS - 1));
    assign finish_o   = hit && final_word;

    always_comb begin
        st_d       = st_q;
        st_d.valid = hit;
        st_d.last  = hit && final_word;
        if (hit) begin
            st_d.data     = data_i[st_q.exp_bank];
            st_d.cnt      = st_q.cnt + IDX_W'(1);
            st_d.exp_bank = st_q.exp_bank + BANK_W'(1);
        end
        if (start_i) begin
            st_d.cnt      = '0;
            st_d.exp_bank = start_bank_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.valid;
    assign rsp_data_o  = st_q.data;
    assign rsp_last_o  = st_q.last;

    // R4: banks finish one at a time
    a_r4_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(done_i));

    // R4: the finishing bank is always the next one in address order
    a_r4_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |-> done_i[st_q.exp_bank]);

    // R5: the last flag is never presented without a word
    a_r5_last_has_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_last_o |-> rsp_valid_o);
endmodule

// File: rtl/ilv_mem_reader.sv
module ilv_mem_reader #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int NUM_BANKS   = 8,
    parameter int ACCESS_LAT  = 6,
    parameter int BLOCK_WORDS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rsp_last_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LOC_W  = ADDR_W - BANK_W;
    localparam int OFS_W  = $clog2(BLOCK_WORDS);

    logic                             active_d, active_q;
    logic                             accept;
    logic                             finish;
    logic [ADDR_W-1:0]                base_addr;
    logic [NUM_BANKS-1:0]             issue_vec;
    logic [NUM_BANKS-1:0]             busy_vec;
    logic [NUM_BANKS-1:0]             done_vec;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
    logic [LOC_W-1:0]                 issue_loc;

    assign req_ready_o = !active_q;
    assign accept      = req_valid_i && req_ready_o;
    assign base_addr   = {req_addr_i[ADDR_W-1:OFS_W], OFS_W'(0)};

    always_comb begin
        active_d = active_q;
        if (accept) begin
            active_d = 1'b1;
        end else if (finish) begin
            active_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active_d;
        end
    end

    ilv_issue #(
        .ADDR_W      (ADDR_W),
        .NUM_BANKS   (NUM_BANKS),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) issue_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (accept),
        .base_i      (base_addr),
        .bank_busy_i (busy_vec),
        .issue_o     (issue_vec),
        .loc_o       (issue_loc)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .ADDR_W     (ADDR_W),
            .DATA_W     (DATA_W),
            .NUM_BANKS  (NUM_BANKS),
            .ACCESS_LAT (ACCESS_LAT),
            .BANK_IDX   (b)
        ) bank_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .issue_i (issue_vec[b]),
            .loc_i   (issue_loc),
            .busy_o  (busy_vec[b]),
            .done_o  (done_vec[b]),
            .data_o  (bank_data[b])
        );
    end

    ilv_return #(
        .DATA_W      (DATA_W),
        .NUM_BANKS   (NUM_BANKS),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) return_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (accept),
        .start_bank_i (base_addr[BANK_W-1:0]),
        .done_i       (done_vec),
        .data_i       (bank_data),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_data_o   (rsp_data_o),
        .rsp_last_o   (rsp_last_o),
        .finish_o     (finish)
    );

    // R7: no request is taken while a block is still being returned
    a_r7_busy_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_last_o) |-> !req_ready_o);

    // R7: ready drops right after an acceptance
    a_r7_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> !req_ready_o);

    // R1: outputs are idle straight after reset
    a_r1_reset_idle: assert property (@(posedge clk_i)
        !rst_ni |=> (!rsp_valid_o && req_ready_o));
endmodule

// File: tb/ilv_mem_reader_tb_top.sv
module ilv_mem_reader_tb_top;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int NUM_BANKS   = 8;
    localparam int ACCESS_LAT  = 6;
    localparam int BLOCK_WORDS = 4;
    localparam int FIRST_T     = ACCESS_LAT + 2;
    localparam int LAST_T      = ACCESS_LAT + BLOCK_WORDS + 1;
    localparam int FLAT_COST   = (1 + ACCESS_LAT + 1) * BLOCK_WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_last;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ilv_mem_reader #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_BANKS   (NUM_BANKS),
        .ACCESS_LAT  (ACCESS_LAT),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_addr_i  (req_addr),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .rsp_last_o  (rsp_last)
    );

    function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'h9E3779B1;
        return DATA_W'(p ^ 32'h3C5A96E1);
    endfunction

    function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'(BLOCK_WORDS - 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive a request at the current negedge; ready must be high (R9 when chained).
    task automatic start_req(input logic [ADDR_W-1:0] a, input string tag);
        chk(tag, 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
    endtask

    // Watch the LAST_T cycles after acceptance. Optionally raise junk requests while busy (R7).
    task automatic observe(input logic [ADDR_W-1:0] a, input bit junk);
        logic [ADDR_W-1:0] base;
        base = align(a);
        for (int t = 1; t <= LAST_T; t++) begin
            @(negedge clk);
            chk("R7 ready", 64'(req_ready), 64'(t >= LAST_T));
            chk("R4 valid timing", 64'(rsp_valid), 64'(t >= FIRST_T));
            if (t >= FIRST_T) begin
                int k;
                k = t - FIRST_T;
                chk("R2 R8 word data", 64'(rsp_data), 64'(exp_word(base + ADDR_W'(k))));
                chk("R5 last flag", 64'(rsp_last), 64'(k == BLOCK_WORDS - 1));
                if (k == BLOCK_WORDS - 1) begin
                    chk("R6 fill cycles", 64'(t), 64'(LAST_T));
                    chk("R6 beats flat memory", 64'(t < FLAT_COST), 64'd1);
                end
            end else begin
                chk("R5 no early last", 64'(rsp_last), 64'd0);
            end
            if (junk && t < LAST_T) begin
                req_valid = 1'b1;
                req_addr  = ADDR_W'($urandom);
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R4 no spurious word", 64'(rsp_valid), 64'd0);
            chk("R7 ready when idle", 64'(req_ready), 64'd1);
        end
    endtask

    initial begin
        logic [ADDR_W-1:0] a;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", 64'(rsp_valid), 64'd0);
        chk("R1 reset ready", 64'(req_ready), 64'd1);

        // Directed: aligned zero, top of space unaligned, small unaligned
        start_req(12'h000, "R1 first request");
        observe(12'h000, 1'b0);
        req_valid = 1'b0;
        idle_cycles(2);
        start_req(12'hFFF, "R8 top request");
        observe(12'hFFF, 1'b0);
        start_req(12'h005, "R9 chained request");  // chained at last-word cycle
        observe(12'h005, 1'b1);                    // R7 junk while busy
        req_valid = 1'b0;
        idle_cycles(1);

        for (int n = 0; n < 60; n++) begin
            bit chain;
            a = ADDR_W'($urandom);
            chain = ($urandom % 2) == 1;
            if (!chain) begin
                req_valid = 1'b0;
                idle_cycles(1 + int'($urandom % 3));
            end
            start_req(a, chain ? "R9 back-to-back ready" : "R7 ready before request");
            observe(a, ($urandom % 2) == 1);
        end
        req_valid = 1'b0;
        idle_cycles(3);

        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule